// File: doc/BRIEF.md
# Compressed-Automaton Byte Stream Matcher

This block scans a byte stream against a deterministic automaton kept in on-chip register storage. To keep storage small, each non-start state holds only a couple of labelled transitions, an accept flag with a rule identifier, and one fallback pointer. The start state alone owns a full 256-entry next-state table.

For each byte, the engine searches the labelled entries of the current state. On a hit, it moves to the target and takes the byte. On a miss, it moves along the fallback pointer without taking the byte and tries the same byte again. This repeats until a labelled hit occurs or the start state is reached, where the full table always resolves the byte. Fallback pointers always lead to states closer to the start, so a chase always ends.

The bytes arrive on a valid/ready stream. A start-of-flow pulse puts the engine back at the start state. The tables are loaded through a simple write port before scanning begins.

Top module: `dfa_matcher`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `match_valid` is 0 and the current state is the start state (index 0).
- R2: In the start state, every byte is taken in one cycle with no stall, and the next state is the start-table entry addressed by the byte value.
- R3: In a non-start state, a byte that equals the symbol of a valid labelled entry is taken in the handshake cycle with no stall, and the next state is that entry's target.
- R4: A byte that misses in a non-start state is latched. `in_ready` then stays 0 while the engine follows fallback pointers, one state fetch per cycle, retrying the latched byte each time. The number of stall cycles equals the fetch count minus one.
- R5: A fallback chase always ends, at the start state at the latest, and the start state always takes the byte.
- R6: In the cycle after the clock edge at which a byte is taken, `match_valid` is 1 exactly when the entered state has its accept flag set. `match_rule` then shows that state's rule identifier, and is 0 whenever `match_valid` is 0.
- R7: While `sof` is 1, `in_ready` is 0 and no byte is taken. On the following edge, the state returns to 0 and any latched byte is dropped. In the next cycle, `match_valid` is 0.
- R8: A write with `tbl_we`=1 and `tbl_sel`=0 stores `tbl_wdata` as the entry of state `tbl_addr`. A write with `tbl_sel`=1 stores `tbl_wdata[3:0]` as the start-table target for byte `tbl_addr`. The entry layout, from MSB to LSB, is: accept[38], rule[37:30], fallback[29:26], label 1[25:13], label 0[12:0]. Each label field is {valid, symbol[7:0], target[3:0]}.
- R9: When both labelled entries of a state are valid and carry the same symbol, label 0 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start-of-flow pulse |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_byte | input | 8 | Input byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0: state entry, 1: start-table entry |
| tbl_addr | input | 8 | State index or byte value |
| tbl_wdata | input | 39 | Write data (layout in R8) |
| match_valid | output | 1 | Entered state accepts |
| match_rule | output | 8 | Rule identifier of the accepting state |

## Verification
The hardest case to reach from the ports is a long fallback chase cut short by a start-of-flow pulse while a latched byte is still pending. A randomly built automaton rarely walks deep enough to produce either on its own. The bench therefore wires a fixed four-hop fallback chain from the deepest state to the start state, and sends a byte that no labelled entry carries to force the full chase. It also aborts another chase with a pulse one cycle after the handshake, then checks that the next byte resolves from the start table.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    localparam int NSTATES = 16;
    localparam int SW      = $clog2(NSTATES);
    localparam int NLAB    = 2;
    localparam int RW      = 8;
    localparam int CW      = 8;
    localparam int LW      = 1 + CW + SW;
    localparam int EW      = 1 + RW + SW + NLAB * LW;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] sym;
        logic [SW-1:0] nxt;
    } lab_t;

    typedef struct packed {
        logic            acc;
        logic [RW-1:0]   rule;
        logic [SW-1:0]   dflt;
        lab_t [NLAB-1:0] lab;
    } ent_t;

    typedef enum logic {ST_SCAN, ST_CHASE} fsm_t;
endpackage

// File: rtl/dfa_regfile.sv
module dfa_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dfa_label_search.sv
module dfa_label_search
    import dfa_pkg::*;
(
    input  lab_t [NLAB-1:0] labs,
    input  logic [CW-1:0]   ch,
    output logic            hit,
    output logic [SW-1:0]   nxt
);
    logic [NLAB-1:0] eq;

    for (genvar i = 0; i < NLAB; i++) begin : g_cmp
        assign eq[i] = labs[i].vld && (labs[i].sym == ch);
    end

    // lowest index wins: scan downward so the last write is entry 0
    always_comb begin
        hit = 1'b0;
        nxt = '0;
        for (int i = NLAB - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                nxt = labs[i].nxt;
            end
        end
    end
endmodule

// File: rtl/dfa_matcher.sv
module dfa_matcher
    import dfa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_byte,
    input  logic          tbl_we,
    input  logic          tbl_sel,
    input  logic [7:0]    tbl_addr,
    input  logic [EW-1:0] tbl_wdata,
    output logic          match_valid,
    output logic [RW-1:0] match_rule
);
    fsm_t          fsm_q, fsm_d;
    logic [SW-1:0] cur_q, cur_d;
    logic [CW-1:0] hold_q, hold_d;
    logic          entered_q;

    logic [EW-1:0] ent_bits;
    ent_t          ent;
    logic [CW-1:0] ch;
    logic [SW-1:0] root_nxt, lab_nxt, tgt;
    logic          hit, at_root, take, step, consume, chasing;
    logic          st_we, rt_we;

    assign st_we = tbl_we && !tbl_sel && (32'(tbl_addr) < NSTATES);
    assign rt_we = tbl_we && tbl_sel;

    dfa_regfile #(.DEPTH(NSTATES), .WIDTH(EW)) u_state (
        .clk   (clk),
        .we    (st_we),
        .waddr (tbl_addr[SW-1:0]),
        .wdata (tbl_wdata),
        .raddr (cur_q),
        .rdata (ent_bits)
    );

    dfa_regfile #(.DEPTH(1 << CW), .WIDTH(SW)) u_root (
        .clk   (clk),
        .we    (rt_we),
        .waddr (tbl_addr[CW-1:0]),
        .wdata (tbl_wdata[SW-1:0]),
        .raddr (ch),
        .rdata (root_nxt)
    );

    assign ent = ent_t'(ent_bits);
    assign ch  = (fsm_q == ST_SCAN) ? in_byte : hold_q;

    dfa_label_search u_search (
        .labs (ent.lab),
        .ch   (ch),
        .hit  (hit),
        .nxt  (lab_nxt)
    );

    assign chasing  = (fsm_q == ST_CHASE);
    assign at_root  = (cur_q == '0);
    assign in_ready = (fsm_q == ST_SCAN) && !sof;
    assign take     = in_valid && in_ready;
    assign step     = take || (chasing && !sof);
    assign consume  = step && (at_root || hit);
    assign tgt      = at_root ? root_nxt : lab_nxt;

    // next-state logic
    always_comb begin
        fsm_d  = fsm_q;
        cur_d  = cur_q;
        hold_d = hold_q;
        if (sof) begin
            fsm_d = ST_SCAN;
            cur_d = '0;
        end else begin
            unique case (fsm_q)
                ST_SCAN: begin
                    if (take) begin
                        if (consume) begin
                            cur_d = tgt;
                        end else begin
                            cur_d  = ent.dflt;
                            hold_d = in_byte;
                            fsm_d  = ST_CHASE;
                        end
                    end
                end
                ST_CHASE: begin
                    if (consume) begin
                        cur_d = tgt;
                        fsm_d = ST_SCAN;
                    end else begin
                        cur_d = ent.dflt;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q     <= ST_SCAN;
            cur_q     <= '0;
            hold_q    <= '0;
            entered_q <= 1'b0;
        end else begin
            fsm_q     <= fsm_d;
            cur_q     <= cur_d;
            hold_q    <= hold_d;
            entered_q <= consume && !sof;
        end
    end

    // outputs
    always_comb begin
        match_valid = entered_q && ent.acc;
        match_rule  = match_valid ? ent.rule : '0;
    end
endmodule

// File: rtl/dfa_matcher_chk.sv
module dfa_matcher_chk #(
    parameter int NS = 16,
    localparam int SWC = $clog2(NS),
    localparam int CNTW = $clog2(NS + 1) + 1
) (
    input logic           clk,
    input logic           rst,
    input logic           sof,
    input logic           in_ready,
    input logic           match_valid,
    input logic           consume,
    input logic           chasing,
    input logic [SWC-1:0] cur_state
);
    logic [CNTW-1:0] chase_len;

    always_ff @(posedge clk) begin
        if (rst || !chasing) chase_len <= '0;
        else                 chase_len <= chase_len + 1'b1;
    end

    a_r4_no_ready_in_chase: assert property (@(posedge clk) disable iff (rst)
        chasing |-> !in_ready);

    a_r5_root_consumes: assert property (@(posedge clk) disable iff (rst)
        (chasing && cur_state == '0 && !sof) |-> consume);

    a_r5_chase_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(chase_len) < NS);

    a_r6_match_after_take: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(consume));

    a_r7_sof_to_start: assert property (@(posedge clk) disable iff (rst)
        $past(sof) |-> cur_state == '0);

    a_r7_sof_no_match: assert property (@(posedge clk) disable iff (rst)
        $past(sof) |-> !match_valid);
endmodule

bind dfa_matcher dfa_matcher_chk #(.NS(dfa_pkg::NSTATES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sof         (sof),
    .in_ready    (in_ready),
    .match_valid (match_valid),
    .consume     (consume),
    .chasing     (chasing),
    .cur_state   (cur_q)
);

// File: tb/sim_dfa_matcher.sv
module sim_dfa_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst, sof, in_valid, in_ready, tbl_we, tbl_sel;
    logic [7:0]  in_byte, tbl_addr, match_rule;
    logic [38:0] tbl_wdata;
    logic        match_valid;

    int checks = 0;
    int fails  = 0;

    bit       m_acc [16];
    bit [7:0] m_rule[16];
    int       m_dft [16];
    bit       m_lv  [16][2];
    bit [7:0] m_ls  [16][2];
    int       m_lt  [16][2];
    int       m_root[256];
    int       m_cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dfa_matcher u0 (
        .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .match_valid(match_valid), .match_rule(match_rule)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [38:0] pack_ent(input int s);
        logic [12:0] l0, l1;
        l0 = {m_lv[s][0], m_ls[s][0], 4'(m_lt[s][0])};
        l1 = {m_lv[s][1], m_ls[s][1], 4'(m_lt[s][1])};
        return {m_acc[s], m_rule[s], 4'(m_dft[s]), l1, l0};
    endfunction

    task automatic wr(input bit sel, input int addr, input logic [38:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 8'(addr); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // reference walk: returns target state and number of state fetches
    task automatic model_step(input bit [7:0] b, output int nxt, output int fe,
                              output string tg);
        int s;
        int f;
        bit done;
        s = m_cur; fe = 1; done = 0; nxt = 0;
        while (!done) begin
            if (s == 0) begin
                nxt = m_root[b]; done = 1;
            end else begin
                f = -1;
                for (int i = 0; i < 2; i++)
                    if (f < 0 && m_lv[s][i] && m_ls[s][i] == b) f = i;
                if (f >= 0) begin
                    nxt = m_lt[s][f]; done = 1;
                end else begin
                    s = m_dft[s]; fe++;
                end
            end
        end
        if (fe > 1)        tg = "R4";
        else if (m_cur==0) tg = "R2";
        else               tg = "R3";
    endtask

    task automatic send(input bit [7:0] b, input string tagov);
        int nxt, fe, st;
        string tg, mt;
        model_step(b, nxt, fe, tg);
        if (tagov != "") tg = tagov;
        mt = (tagov != "") ? tagov : "R6";
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; st = 0;
        while (!in_ready) begin st++; @(negedge clk); end
        chk(st == fe - 1, tg, "stall cycles", st, fe - 1);
        chk(match_valid == m_acc[nxt], mt, "match flag", int'(match_valid), int'(m_acc[nxt]));
        chk(match_rule == (m_acc[nxt] ? m_rule[nxt] : 8'd0), mt, "rule id",
            int'(match_rule), m_acc[nxt] ? int'(m_rule[nxt]) : 0);
        m_cur = nxt;
    endtask

    task automatic sof_pulse();
        @(negedge clk);
        sof = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R7", "ready during sof", int'(in_ready), 0);
        @(negedge clk);
        sof = 1'b0;
        #1;
        chk(match_valid == 1'b0, "R7", "match after sof", int'(match_valid), 0);
        m_cur = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R0 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; sof = 1'b0; in_valid = 1'b0; in_byte = '0;
        tbl_we = 1'b0; tbl_sel = 1'b0; tbl_addr = '0; tbl_wdata = '0;
        m_cur = 0;

        // random automaton, fallbacks only toward shallower groups of four
        for (int s = 0; s < 16; s++) begin
            int grp_first;
            grp_first = (s == 0) ? 0 : 1 + 4 * ((s - 1) / 4);
            m_acc[s]  = (s != 0) && ($urandom % 4 == 0);
            m_rule[s] = 8'($urandom % 255 + 1);
            m_dft[s]  = (grp_first == 0) ? 0 : int'($urandom % grp_first);
            for (int i = 0; i < 2; i++) begin
                m_lv[s][i] = (i == 0) ? 1'b1 : 1'($urandom % 2);
                m_ls[s][i] = 8'("a" + $urandom % 4);
                m_lt[s][i] = int'($urandom % 16);
            end
        end
        for (int c = 0; c < 256; c++) m_root[c] = int'($urandom % 16);
        // directed structure
        m_root["q"] = 5; m_root["r"] = 13;
        m_lv[5][0] = 1; m_ls[5][0] = "c"; m_lt[5][0] = 7;
        m_lv[5][1] = 1; m_ls[5][1] = "c"; m_lt[5][1] = 9;
        m_acc[7] = 1; m_rule[7] = 8'h77;
        m_acc[9] = 1; m_rule[9] = 8'h99;
        m_dft[13] = 9; m_dft[9] = 5; m_dft[5] = 1; m_dft[1] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        chk(match_valid == 1'b0, "R1", "match after reset", int'(match_valid), 0);

        // R8: load both tables through the write port
        for (int s = 0; s < 16; s++) wr(1'b0, s, pack_ent(s));
        for (int c = 0; c < 256; c++) wr(1'b1, c, 39'(m_root[c]));

        send("q", "R2");
        send("c", "R9");            // both labels carry 'c': label 0 -> state 7
        sof_pulse();
        send("r", "R2");
        send("z", "R5");            // 13 -> 9 -> 5 -> 1 -> 0: four stalls

        // R7: abort a chase with a start-of-flow pulse
        while (m_cur == 0) send(8'("a" + $urandom % 4), "");
        @(negedge clk);
        in_valid = 1'b1; in_byte = "z";
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R4", "ready low in chase", int'(in_ready), 0);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R7", "ready after abort", int'(in_ready), 1);
        chk(match_valid == 1'b0, "R7", "match after abort", int'(match_valid), 0);
        m_cur = 0;
        send("q", "R7");

        // R8: rewrite a start-table target and observe it
        m_root["q"] = 9;
        wr(1'b1, "q", 39'd9);
        sof_pulse();
        send("q", "R8");

        for (int n = 0; n < 400; n++) begin
            if ($urandom % 40 == 0) sof_pulse();
            send(8'("a" + $urandom % 6), "");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule